// File: doc/BRIEF.md
# Extended Arithmetic Sequencer

This block is a multicycle arithmetic engine. It works on three 16-bit registers of a neighbouring register file (two operand registers, called AX and AY here, and a first general register, GR1) and on a one-bit link flag. A two-bit command picks one of four operations: unsigned multiply, divide, arithmetic right shift, or normalize. GR1 serves two roles. For multiply and divide it holds half of a 32-bit value. For the shift operations it is a step counter that counts upward.

On acceptance, the unit copies the register values into working registers. It then iterates one step per clock and presents the final values on its write port, together with a one-cycle write strobe. The register file loads them on that edge. In the next cycle `done` pulses. `busy` is high from the first iteration cycle through the write-back cycle.

States: IDLE (waiting), MUL (one shift-add step per clock), DIV (one restoring-divide step per clock), SHR (one arithmetic-right-shift step per clock), NRM (one normalize step per clock), WB (write strobe) and FIN (done pulse).

Transitions:
- From IDLE or FIN, an accepted command goes to MUL, DIV, SHR or NRM.
- A faulting divide, or a normalize of an all-zero pair, goes straight to WB.
- MUL and DIV go to WB after their 16th step.
- SHR goes to WB when GR1 wraps to zero or when the step limit is reached.
- NRM goes to WB once AX bit 15 differs from AX bit 14.
- WB always goes to FIN.
- FIN goes back to IDLE, or straight to a new operation when a command is waiting.

Top module: `xarith_seq`

## Requirements
- R1: Multiply (op code 0) writes the high half of the unsigned 32-bit product AX*AY to AX and the low half to GR1. AY and the link are written back unchanged.
- R2: Divide (op code 1) with AY nonzero and AX < AY divides the dividend {AX,GR1} by AY. It writes the quotient to GR1 and the remainder to AX, leaves AY unchanged and clears the link.
- R3: Divide with AY = 0 or AX >= AY writes AX, AY and GR1 back unchanged and sets the link. The write strobe comes in the cycle right after acceptance.
- R4: Arithmetic right shift (op code 2) loads the link with AX bit 15. Each step shifts {AX,AY} right by one, copying AX bit 15 into the top bit, and adds one to GR1. The shift always takes at least one step and stops after the step in which GR1 becomes zero.
- R5: Arithmetic right shift stops after 32 steps even if GR1 has not reached zero.
- R6: Normalize (op code 3) with AX = AY = 0 writes all registers back unchanged, in the cycle right after acceptance.
- R7: Normalize with a nonzero pair shifts {AX,AY} left by one per step, filling with zero, and adds one to GR1 per step. It stops when AX bit 15 differs from AX bit 14, which may be before the first step. The link is unchanged.
- R8: Counting the acceptance cycle as cycle 0:
  - `busy` is high in cycle 1.
  - Multiply and divide strobe the write in cycle 17 and pulse `done` in cycle 18.
  - A shift of n steps strobes in cycle n+1.
  - A normalize of k steps strobes in cycle k+2.
  - `done` follows the strobe by one cycle and lasts one cycle.
- R9: A command presented while `busy` is high is ignored. The running operation completes with its own result and timing, and no second operation starts.
- R10: After reset, `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request; accepted when `busy` is low |
| cmd_op | input | 2 | 0 multiply, 1 divide, 2 arithmetic right shift, 3 normalize |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse after write-back |
| ax_in | input | 16 | Current AX from register file |
| ay_in | input | 16 | Current AY from register file |
| gr_in | input | 16 | Current GR1 from register file |
| link_in | input | 1 | Current link flag |
| wr_en | output | 1 | Write strobe for all four results |
| ax_out | output | 16 | New AX |
| ay_out | output | 16 | New AY |
| gr_out | output | 16 | New GR1 |
| link_out | output | 1 | New link flag |

## Verification
A wrong state or a wrong step counter shows up first as a shift in the write-strobe cycle. The bench catches this in the same run, because it counts cycles from acceptance to `done` for every operation. A corrupted working register shows up as a wrong value loaded into the register-file model at the strobe, and is seen one cycle later when `done` rises. A step that is dropped or repeated in a loop changes both the count and the values. A wrongly accepted mid-run command changes the final result of that same operation.

// File: rtl/xarith_pkg.sv
package xarith_pkg;

    typedef enum logic [1:0] {
        XOP_MUL = 2'd0,
        XOP_DIV = 2'd1,
        XOP_ASR = 2'd2,
        XOP_NRM = 2'd3
    } xop_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV,
        ST_SHR,
        ST_NRM,
        ST_WB,
        ST_FIN
    } xstate_e;

endpackage

// File: rtl/xarith_mul_step.sv
module xarith_mul_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] mcand_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    logic [W:0] sum;

    always_comb begin
        sum  = {1'b0, hi_i} + (lo_i[0] ? {1'b0, mcand_i} : '0);
        hi_o = sum[W:1];
        lo_o = {sum[0], lo_i[W-1:1]};
    end
endmodule

// File: rtl/xarith_div_step.sv
module xarith_div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0]   trial;
    logic [W-1:0] diff;
    logic         fits;

    always_comb begin
        trial = {rem_i, quo_i[W-1]};
        fits  = trial >= {1'b0, dvs_i};
        diff  = trial[W-1:0] - dvs_i;
        rem_o = fits ? diff : trial[W-1:0];
        quo_o = {quo_i[W-2:0], fits};
    end
endmodule

// File: rtl/xarith_shift_step.sv
module xarith_shift_step #(
    parameter int W = 16
) (
    input  logic         left_i,
    input  logic [W-1:0] ax_i,
    input  logic [W-1:0] ay_i,
    input  logic [W-1:0] gr_i,
    output logic [W-1:0] ax_o,
    output logic [W-1:0] ay_o,
    output logic [W-1:0] gr_o,
    output logic         gr_zero_o,
    output logic         normed_o
);
    always_comb begin
        if (left_i) begin
            ax_o = {ax_i[W-2:0], ay_i[W-1]};
            ay_o = {ay_i[W-2:0], 1'b0};
        end else begin
            ax_o = {ax_i[W-1], ax_i[W-1:1]};
            ay_o = {ax_i[0], ay_i[W-1:1]};
        end
        gr_o      = gr_i + 1'b1;
        gr_zero_o = (gr_o == '0);
        normed_o  = ax_i[W-1] != ax_i[W-2];
    end
endmodule

// File: rtl/xarith_seq.sv
module xarith_seq
    import xarith_pkg::*;
#(
    parameter int W           = 16,
    parameter int SHIFT_LIMIT = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [1:0]   cmd_op,
    output logic         busy,
    output logic         done,
    input  logic [W-1:0] ax_in,
    input  logic [W-1:0] ay_in,
    input  logic [W-1:0] gr_in,
    input  logic         link_in,
    output logic         wr_en,
    output logic [W-1:0] ax_out,
    output logic [W-1:0] ay_out,
    output logic [W-1:0] gr_out,
    output logic         link_out
);
    localparam int CNT_MAX = (SHIFT_LIMIT > W) ? SHIFT_LIMIT : W;
    localparam int CW      = $clog2(CNT_MAX) + 1;
    localparam logic [CW-1:0] LAST_MD  = CW'(W - 1);
    localparam logic [CW-1:0] LAST_SHR = CW'(SHIFT_LIMIT - 1);

    xstate_e       state_q, state_d;
    logic [W-1:0]  ax_q, ay_q, gr_q, opnd_q;
    logic          lnk_q;
    logic [CW-1:0] cnt_q;

    logic          accept, div_fault, nrm_zero;
    xop_e          op_in;
    logic [W-1:0]  mul_hi, mul_lo, div_rem, div_quo;
    logic [W-1:0]  sh_ax, sh_ay, sh_gr;
    logic          sh_gr_zero, sh_normed;

    assign op_in     = xop_e'(cmd_op);
    assign accept    = cmd_valid && (state_q == ST_IDLE || state_q == ST_FIN);
    assign div_fault = (ay_in == '0) || (ax_in >= ay_in);
    assign nrm_zero  = (ax_in == '0) && (ay_in == '0);

    xarith_mul_step #(.W(W)) u_mul (
        .hi_i(ax_q), .lo_i(gr_q), .mcand_i(opnd_q),
        .hi_o(mul_hi), .lo_o(mul_lo)
    );

    xarith_div_step #(.W(W)) u_div (
        .rem_i(ax_q), .quo_i(gr_q), .dvs_i(opnd_q),
        .rem_o(div_rem), .quo_o(div_quo)
    );

    xarith_shift_step #(.W(W)) u_shf (
        .left_i(state_q == ST_NRM),
        .ax_i(ax_q), .ay_i(ay_q), .gr_i(gr_q),
        .ax_o(sh_ax), .ay_o(sh_ay), .gr_o(sh_gr),
        .gr_zero_o(sh_gr_zero), .normed_o(sh_normed)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                state_d = ST_IDLE;
                if (accept) begin
                    unique case (op_in)
                        XOP_MUL: state_d = ST_MUL;
                        XOP_DIV: state_d = div_fault ? ST_WB : ST_DIV;
                        XOP_ASR: state_d = ST_SHR;
                        XOP_NRM: state_d = nrm_zero ? ST_WB : ST_NRM;
                        default: state_d = ST_IDLE;
                    endcase
                end
            end
            ST_MUL, ST_DIV: if (cnt_q == LAST_MD) state_d = ST_WB;
            ST_SHR: if (sh_gr_zero || cnt_q == LAST_SHR) state_d = ST_WB;
            ST_NRM: if (sh_normed) state_d = ST_WB;
            ST_WB:   state_d = ST_FIN;
            default: state_d = ST_IDLE;
        endcase
    end

    // working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ax_q   <= '0;
            ay_q   <= '0;
            gr_q   <= '0;
            opnd_q <= '0;
            lnk_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            cnt_q  <= '0;
            ax_q   <= ax_in;
            ay_q   <= ay_in;
            gr_q   <= gr_in;
            opnd_q <= ay_in;
            lnk_q  <= link_in;
            unique case (op_in)
                XOP_MUL: begin
                    ax_q   <= '0;
                    gr_q   <= ay_in;
                    opnd_q <= ax_in;
                end
                XOP_DIV: lnk_q <= div_fault;
                XOP_ASR: lnk_q <= ax_in[W-1];
                default: ;
            endcase
        end else begin
            unique case (state_q)
                ST_MUL: begin
                    ax_q  <= mul_hi;
                    gr_q  <= mul_lo;
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_DIV: begin
                    ax_q  <= div_rem;
                    gr_q  <= div_quo;
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_SHR: begin
                    ax_q  <= sh_ax;
                    ay_q  <= sh_ay;
                    gr_q  <= sh_gr;
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_NRM: if (!sh_normed) begin
                    ax_q  <= sh_ax;
                    ay_q  <= sh_ay;
                    gr_q  <= sh_gr;
                    cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy     = (state_q != ST_IDLE) && (state_q != ST_FIN);
        wr_en    = (state_q == ST_WB);
        done     = (state_q == ST_FIN);
        ax_out   = ax_q;
        ay_out   = ay_q;
        gr_out   = gr_q;
        link_out = lnk_q;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_WR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> done); // R8
    AST_DIV_FAULT_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == 2'd1 && ay_in == '0)
        |=> (wr_en && link_out && ax_out == $past(ax_in) && gr_out == $past(gr_in))); // R3
    AST_NRM_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == 2'd3 && ax_in == '0 && ay_in == '0)
        |=> (wr_en && ax_out == '0 && ay_out == '0 && gr_out == $past(gr_in))); // R6
    AST_ASR_LINK_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cmd_op == 2'd2) |=> (link_out == $past(ax_in[W-1]))); // R4
    AST_SHR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHR) |-> (cnt_q <= LAST_SHR)); // R5
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wr_en) |=> $stable(opnd_q)); // R9

endmodule

// File: tb/xarith_seq_tb.sv
module xarith_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        busy, done, wr_en, link_out;
    logic [15:0] ax_out, ay_out, gr_out;

    logic [15:0] rax = 16'h0, ray = 16'h0, rgr = 16'h0;
    logic        rlk = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cyc_total = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    xarith_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .busy(busy), .done(done),
        .ax_in(rax), .ay_in(ray), .gr_in(rgr), .link_in(rlk),
        .wr_en(wr_en), .ax_out(ax_out), .ay_out(ay_out), .gr_out(gr_out),
        .link_out(link_out)
    );

    // register file model
    always @(posedge clk) if (wr_en) begin
        rax <= ax_out; ray <= ay_out; rgr <= gr_out; rlk <= link_out;
    end

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 100000 && !finished) begin
            fails++;
            $display("FAIL watchdog: run did not end (actual timeout, expected completion)");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference model: returns expected registers and cycles from acceptance to done
    task automatic ref_exec(input logic [1:0] op, inout logic [15:0] ax, inout logic [15:0] ay,
                            inout logic [15:0] gr, inout logic lk, output int cyc);
        logic [31:0] t;
        int n;
        case (op)
            2'd0: begin t = ax * ay; ax = t[31:16]; gr = t[15:0]; cyc = 17; end
            2'd1: begin
                if (ay != 0 && ax < ay) begin
                    t = {ax, gr}; gr = 16'(t / ay); ax = 16'(t % ay); lk = 0; cyc = 17;
                end else begin lk = 1; cyc = 1; end
            end
            2'd2: begin
                lk = ax[15]; n = 0;
                do begin
                    t = {ax, ay}; t = $signed(t) >>> 1; ax = t[31:16]; ay = t[15:0];
                    gr = gr + 1; n++;
                end while (gr != 0 && n < 32);
                cyc = n + 1;
            end
            default: begin
                if ((ax | ay) == 0) cyc = 1;
                else begin
                    n = 0;
                    while (ax[15] == ax[14]) begin
                        t = {ax, ay} << 1; ax = t[31:16]; ay = t[15:0]; gr = gr + 1; n++;
                    end
                    cyc = n + 2;
                end
            end
        endcase
    endtask

    // issue one command, optionally a stray command while busy, and check everything
    task automatic run_op(input string req, input logic [1:0] op,
                          input logic [15:0] ax, input logic [15:0] ay,
                          input logic [15:0] gr, input logic lk, input bit stray);
        logic [15:0] eax, eay, egr;
        logic elk;
        int ecyc, cyc;
        @(negedge clk);
        rax = ax; ray = ay; rgr = gr; rlk = lk;
        eax = ax; eay = ay; egr = gr; elk = lk;
        ref_exec(op, eax, eay, egr, elk, ecyc);
        cmd_op = op; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk({req, " R8 busy in cycle 1"}, 32'(busy), 32'(ecyc > 1 ? 1 : 1));
        cyc = 0;
        while (!done && cyc < 200) begin
            if (stray && cyc == 3) begin cmd_op = ~op; cmd_valid = 1'b1; end
            @(negedge clk);
            cmd_valid = 1'b0;
            cyc++;
        end
        chk({req, " R8 cycles to done"}, 32'(cyc), 32'(ecyc));
        chk({req, " AX"}, 32'(rax), 32'(eax));
        chk({req, " AY"}, 32'(ray), 32'(eay));
        chk({req, " GR1"}, 32'(rgr), 32'(egr));
        chk({req, " link"}, 32'(rlk), 32'(elk));
        @(negedge clk);
        chk({req, " R8 done one cycle"}, 32'(done), 32'd0);
        chk({req, " R9 idle after"}, 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 busy", 32'(busy), 0);
        chk("R10 done", 32'(done), 0);
        chk("R10 wr_en", 32'(wr_en), 0);
        rst_n = 1'b1;

        run_op("R1 mul a",        2'd0, 16'h1234, 16'h5678, 16'h9999, 1'b1, 0);
        run_op("R1 mul max",      2'd0, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, 0);
        run_op("R1 mul zero",     2'd0, 16'h0000, 16'hABCD, 16'h1111, 1'b1, 0);
        run_op("R2 div a",        2'd2 - 2'd1, 16'h0012, 16'h1234, 16'h3456, 1'b1, 0);
        run_op("R2 div b",        2'd1, 16'h7FFE, 16'hFFFF, 16'hFFFF, 1'b1, 0);
        run_op("R3 div by zero",  2'd1, 16'h0005, 16'h0000, 16'h4321, 1'b0, 0);
        run_op("R3 div ax>=ay",   2'd1, 16'h0005, 16'h0005, 16'h0042, 1'b0, 0);
        run_op("R4 asr 3 steps",  2'd2, 16'h8421, 16'h1357, 16'hFFFD, 1'b0, 0);
        run_op("R4 asr 1 step",   2'd2, 16'h4000, 16'h0001, 16'hFFFF, 1'b1, 0);
        run_op("R5 asr limit",    2'd2, 16'hC003, 16'hAAAA, 16'h0005, 1'b0, 0);
        run_op("R5 asr gr zero",  2'd2, 16'h1234, 16'h5678, 16'h0000, 1'b1, 0);
        run_op("R6 nrm zero",     2'd3, 16'h0000, 16'h0000, 16'h0077, 1'b1, 0);
        run_op("R7 nrm already",  2'd3, 16'h4000, 16'h1234, 16'h0010, 1'b0, 0);
        run_op("R7 nrm low word", 2'd3, 16'h0000, 16'h0001, 16'hFFE0, 1'b1, 0);
        run_op("R7 nrm negative", 2'd3, 16'hFFFF, 16'hF000, 16'h0000, 1'b0, 0);
        run_op("R9 stray on mul", 2'd0, 16'h00FF, 16'h0101, 16'h0000, 1'b0, 1);
        run_op("R9 stray on div", 2'd1, 16'h0001, 16'h0003, 16'h0000, 1'b0, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule